// File: doc/BRIEF.md
# Multiplexed-Bus Static RAM Slave

This block is a byte-wide static memory for a processor bus that carries the address and the data on the same lines. An address strobe marks the address phase. On the strobe's high-to-low transition the block captures the low address byte from the shared lines, the two upper address bits and both chip-enable inputs. The captured enables decide whether the array is powered up. The captured address selects one of 1024 byte locations for the data phase that follows.

During the data phase the block uses its active-low read, write and chip-select inputs. Chip select is never captured. It is used live, so that outside decode logic has as long as possible to settle. The shared lines are modelled as three separate signals: an input bus, an output bus and an output enable.

The whole block is clocked. Every strobe is a level that is sampled on the clock. An edge is seen as a change between two successive samples.

Top module: `mux_bus_sram`

## Requirements
- R1: A falling address strobe is one clock sample with `aleIn` high followed by a sample with it low. At that sample the block captures `adIn`, `addrHi`, `ce1N` and `ce2`, and it keeps all four unchanged until the next falling strobe.
- R2: `powerUp` is 1 only while the captured `ce1N` is 0 and the captured `ce2` is 1. After reset it is 0 (powered down). It can change only in the cycle after a falling address strobe.
- R3: Chip select is not captured. The live level of `csN` enables or disables an access at any time, with no new address strobe needed.
- R4: When powered up with `csN`=0, `rdN`=0 and `wrN`=1, `adOe` is 1 and `adOut` shows the byte stored at the captured address, with no clock delay.
- R5: A write takes place when `wrN` is sampled low and then high on the next clock. In the low sample the block must be powered up with `csN`=0 and `rdN`=1. The byte on `adIn` in the high sample is stored at the captured address. While `wrN` is low, `adOe` stays 0.
- R6: When powered down, or when `csN` is 1, `adOe` is 0 and no byte is stored.
- R7: When enabled with `rdN` and `wrN` both 1, `adOe` is 0 and no byte is stored.
- R8: `rdN` and `wrN` both low is illegal: `adOe` is 0, and that window never leads to a stored byte.
- R9: The location is the 10-bit value {`addrHi`, `adIn`} captured by the strobe. Locations 0 and 1023 are distinct and both can be reached.
- R10: Whenever `adOe` is 0, `adOut` is 8'h00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| aleIn | input | 1 | Address strobe. Capture happens on its falling sample |
| adIn | input | 8 | Shared lines as seen by the block: low address byte, or write data |
| adOut | output | 8 | Byte the block drives onto the shared lines |
| adOe | output | 1 | Output enable for the shared lines |
| addrHi | input | 2 | Upper address bits, captured with the strobe |
| ce1N | input | 1 | Chip enable, active low, captured with the strobe |
| ce2 | input | 1 | Chip enable, active high, captured with the strobe |
| csN | input | 1 | Live chip select, active low |
| rdN | input | 1 | Read strobe, active low |
| wrN | input | 1 | Write strobe, active low |
| powerUp | output | 1 | 1 while the captured enables keep the array powered |

## Verification
The assertions assume that every input is a clean level sampled on the clock. They also assume that a write strobe rises only after at least one low sample, and that the write data is stable in the sample where `wrN` rises. The directed stimulus changes inputs only on the falling clock edge. It holds the write data through the rising sample of `wrN` and releases chip select one cycle later. The random phase also keeps every change on the falling edge, so the per-clock reference model sees the same samples as the design.

// File: rtl/mux_bus_sram_pkg.sv
package mux_bus_sram_pkg;
  typedef struct packed {
    logic capture;   // falling address strobe seen in this sample
    logic commit;    // store the byte on the input lines this cycle
    logic drive;     // drive the stored byte onto the output lines
  } sramCtrl_t;
endpackage

// File: rtl/mux_bus_sram_ctrl.sv
module mux_bus_sram_ctrl
  import mux_bus_sram_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      aleIn,
  input  logic      ce1N,
  input  logic      ce2,
  input  logic      csN,
  input  logic      rdN,
  input  logic      wrN,
  output logic      powerUp,
  output sramCtrl_t ctrl
);
  logic aleQ;
  logic ce1NQ;
  logic ce2Q;
  logic writeArmQ;
  logic accessOn;

  assign ctrl.capture = aleQ & ~aleIn;
  assign powerUp      = ~ce1NQ & ce2Q;
  assign accessOn     = powerUp & ~csN;
  assign ctrl.drive   = accessOn & ~rdN & wrN;
  assign ctrl.commit  = writeArmQ & wrN;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      aleQ      <= 1'b0;
      ce1NQ     <= 1'b1;
      ce2Q      <= 1'b0;
      writeArmQ <= 1'b0;
    end else begin
      aleQ      <= aleIn;
      writeArmQ <= accessOn & ~wrN & rdN;
      if (ctrl.capture) begin
        ce1NQ <= ce1N;
        ce2Q  <= ce2;
      end
    end
  end
endmodule

// File: rtl/mux_bus_sram_dp.sv
module mux_bus_sram_dp
  import mux_bus_sram_pkg::*;
#(
  parameter int LO_W = 8,
  parameter int HI_W = 2
) (
  input  logic            clk,
  input  sramCtrl_t       ctrl,
  input  logic [LO_W-1:0] adIn,
  input  logic [HI_W-1:0] addrHi,
  output logic [LO_W-1:0] adOut
);
  localparam int ADDR_W = LO_W + HI_W;
  localparam int DEPTH  = 1 << ADDR_W;

  logic [ADDR_W-1:0] addrQ;
  logic [LO_W-1:0]   store [DEPTH];

  always_ff @(posedge clk) begin
    if (ctrl.capture) addrQ <= {addrHi, adIn};
  end

  always_ff @(posedge clk) begin
    if (ctrl.commit) store[addrQ] <= adIn;
  end

  assign adOut = ctrl.drive ? store[addrQ] : '0;
endmodule

// File: rtl/mux_bus_sram.sv
module mux_bus_sram
  import mux_bus_sram_pkg::*;
#(
  parameter int LO_W = 8,
  parameter int HI_W = 2
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            aleIn,
  input  logic [LO_W-1:0] adIn,
  output logic [LO_W-1:0] adOut,
  output logic            adOe,
  input  logic [HI_W-1:0] addrHi,
  input  logic            ce1N,
  input  logic            ce2,
  input  logic            csN,
  input  logic            rdN,
  input  logic            wrN,
  output logic            powerUp
);
  sramCtrl_t ctrl;

  mux_bus_sram_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .aleIn(aleIn), .ce1N(ce1N), .ce2(ce2),
    .csN(csN), .rdN(rdN), .wrN(wrN), .powerUp(powerUp), .ctrl(ctrl)
  );

  mux_bus_sram_dp #(.LO_W(LO_W), .HI_W(HI_W)) u_dp (
    .clk(clk), .ctrl(ctrl), .adIn(adIn), .addrHi(addrHi), .adOut(adOut)
  );

  assign adOe = ctrl.drive;
endmodule

// File: rtl/mux_bus_sram_chk.sv
module mux_bus_sram_chk #(
  parameter int LO_W = 8
) (
  input logic            clk,
  input logic            rstN,
  input logic            aleIn,
  input logic [LO_W-1:0] adOut,
  input logic            adOe,
  input logic            csN,
  input logic            rdN,
  input logic            wrN,
  input logic            powerUp
);
  AST_OE_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rstN)
    adOe |-> (powerUp && !csN)); // R6
  AST_OE_ONLY_READ: assert property (@(posedge clk) disable iff (!rstN)
    adOe |-> (!rdN && wrN)); // R4
  AST_ILLEGAL_NO_DRIVE: assert property (@(posedge clk) disable iff (!rstN)
    (!rdN && !wrN) |-> !adOe); // R8
  AST_IDLE_BUS_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    !adOe |-> (adOut == '0)); // R10
  AST_POWER_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !($past(aleIn) && !aleIn) |=> $stable(powerUp)); // R2
endmodule

bind mux_bus_sram mux_bus_sram_chk #(.LO_W(LO_W)) u_chk (
  .clk(clk), .rstN(rstN), .aleIn(aleIn), .adOut(adOut), .adOe(adOe),
  .csN(csN), .rdN(rdN), .wrN(wrN), .powerUp(powerUp)
);

// File: tb/test_mux_bus_sram.sv
module test_mux_bus_sram;
  logic       clk = 0;
  logic       rstN = 0;
  logic       aleIn = 0;
  logic [7:0] adIn = 0;
  logic [7:0] adOut;
  logic       adOe;
  logic [1:0] addrHi = 0;
  logic       ce1N = 1, ce2 = 0, csN = 1, rdN = 1, wrN = 1;
  logic       powerUp;
  int checks = 0, failures = 0;

  always #10 clk = ~clk;

  mux_bus_sram i_mux_bus_sram (
    .clk(clk), .rstN(rstN), .aleIn(aleIn), .adIn(adIn), .adOut(adOut),
    .adOe(adOe), .addrHi(addrHi), .ce1N(ce1N), .ce2(ce2), .csN(csN),
    .rdN(rdN), .wrN(wrN), .powerUp(powerUp)
  );

  // behavioural reference
  logic [7:0] mMem [int];
  int  mAddr = 0;
  bit  mAleQ = 0, mCe1 = 1, mCe2 = 0, mArm = 0;

  function automatic bit mPow();
    return !mCe1 && mCe2;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mAleQ = 0; mCe1 = 1; mCe2 = 0; mArm = 0;
    end else begin
      bit en;
      en = mPow() && !csN;
      if (mArm && wrN) mMem[mAddr] = adIn;
      mArm = en && !wrN && rdN;
      if (mAleQ && !aleIn) begin
        mAddr = {addrHi, adIn};
        mCe1 = ce1N; mCe2 = ce2;
      end
      mAleQ = aleIn;
    end
  end

  task automatic check(input logic [31:0] got, input logic [31:0] exp, input string tag);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%h exp=%h t=%0t", tag, got, exp, $time);
    end
  endtask

  // per-clock comparison, away from the active edge
  always @(negedge clk) begin
    #5;
    if (rstN) begin
      bit eOe;
      logic [7:0] eOut;
      eOe  = mPow() && !csN && !rdN && wrN;
      eOut = eOe ? (mMem.exists(mAddr) ? mMem[mAddr] : 8'hxx) : 8'h00;
      check(powerUp, mPow(), "R2 power");
      check(adOe, eOe, "R6 oe");
      if (!eOe || mMem.exists(mAddr)) check(adOut, eOut, "R4 data");
    end
  end

  task automatic addrPhase(input logic [9:0] a, input logic c1, input logic c2);
    @(negedge clk); aleIn = 1; adIn = a[7:0]; addrHi = a[9:8]; ce1N = c1; ce2 = c2;
    @(negedge clk); aleIn = 0;
    @(negedge clk); adIn = 8'h5A; addrHi = ~a[9:8]; ce1N = ~c1; ce2 = ~c2;
  endtask

  task automatic writeByte(input logic [7:0] d);
    @(negedge clk); csN = 0; adIn = d; wrN = 0;
    #5 check(adOe, 0, "R5 no drive while writing");
    @(negedge clk); wrN = 1;
    @(negedge clk); csN = 1; adIn = 8'h33;
  endtask

  task automatic readByte(input logic [7:0] exp, input logic expOe, input string tag);
    @(negedge clk); csN = 0; rdN = 0;
    #5 check(adOe, expOe, tag);
    check(adOut, expOe ? exp : 8'h00, tag);
    @(negedge clk); rdN = 1; csN = 1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    #5 check(powerUp, 0, "R2 reset powered down");
    check(adOe, 0, "R10 reset idle");
    // R9: extreme locations
    addrPhase(10'd0, 0, 1);
    check(powerUp, 1, "R2 powered by enables");
    writeByte(8'h11);
    addrPhase(10'd1023, 0, 1);
    writeByte(8'hEE);
    addrPhase(10'd0, 0, 1);
    readByte(8'h11, 1, "R9 loc 0");
    addrPhase(10'd1023, 0, 1);
    readByte(8'hEE, 1, "R9 loc 1023");
    // R1: address held while lines change
    @(negedge clk); adIn = 8'h00; addrHi = 2'b00;
    readByte(8'hEE, 1, "R1 address held");
    // R3: live chip select
    @(negedge clk); rdN = 0; csN = 1;
    #5 check(adOe, 0, "R3 cs high blocks");
    @(negedge clk); csN = 0;
    #5 check(adOe, 1, "R3 cs low enables live");
    @(negedge clk); rdN = 1; csN = 1;
    // R7: idle with cs low
    @(negedge clk); csN = 0;
    #5 check(adOe, 0, "R7 idle no drive");
    @(negedge clk); csN = 1;
    readByte(8'hEE, 1, "R7 nothing stored");
    // R6: cs high write ignored
    @(negedge clk); adIn = 8'h77; wrN = 0;
    @(negedge clk); wrN = 1;
    @(negedge clk);
    readByte(8'hEE, 1, "R6 cs high write ignored");
    // R8: both low, then release together
    @(negedge clk); csN = 0; rdN = 0; wrN = 0; adIn = 8'h99;
    #5 check(adOe, 0, "R8 illegal no drive");
    @(negedge clk); rdN = 1; wrN = 1;
    @(negedge clk); csN = 1;
    readByte(8'hEE, 1, "R8 nothing stored");
    // R6: powered down write and read
    addrPhase(10'd1023, 1, 1);
    check(powerUp, 0, "R2 ce1 high powers down");
    writeByte(8'h44);
    readByte(8'h00, 0, "R6 powered down read");
    addrPhase(10'd1023, 0, 0);
    check(powerUp, 0, "R2 ce2 low powers down");
    addrPhase(10'd1023, 0, 1);
    readByte(8'hEE, 1, "R6 powered down write ignored");
    // R5: data taken at the rising write sample
    addrPhase(10'd300, 0, 1);
    @(negedge clk); csN = 0; wrN = 0; adIn = 8'h01;
    @(negedge clk); wrN = 1; adIn = 8'hC3;
    @(negedge clk); csN = 1;
    readByte(8'hC3, 1, "R5 rising-edge data");
    // random phase against the model
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      aleIn = ($urandom % 4) == 0;
      adIn = $urandom; addrHi = $urandom;
      ce1N = ($urandom % 4) == 0; ce2 = ($urandom % 4) != 0;
      csN = $urandom; rdN = $urandom; wrN = $urandom;
    end
    @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule